// File: doc/BRIEF.md
# Up/down counter slice with one-step state recovery

This block is a single m-bit slice of a wide up/down binary counter whose clock period must not grow with the counter's width. The slice owns its count register, a ripple chain of half adder/subtractor cells, a register that remembers which bit positions flipped on the last step, and a three-state direction controller. A separate enable counter, not part of this block, raises `tc` for one cycle whenever this slice is due to step. That is also the only cycle in which `dir` is looked at.

In the full counter a ripple through the slice may take many clock periods, because steps for the slice arrive far apart. A reversal of direction breaks that budget, since the very next step must go the other way. The slice therefore does not ripple on a reversal. It XORs the remembered flip vector into the present value, which undoes the last step in a single gate level. The carry chain keeps working in the direction that produced the present value, so that several reversals in a row still resolve. Seen from outside, every `tc` moves the value by exactly one, up or down as `dir` says. There is no data stream at the edge, so all pins are plain control and status wires with no handshake.

Top module: `updn_slice`

## Requirements
- R1: After asynchronous reset (`rst_n` low) or a synchronous clear (`clr` high at a rising edge), `cnt` reads 0 from the next edge on.
- R2: In a cycle with `tc` low and `clr` low, `cnt` keeps its value at the next edge, whatever `dir` does.
- R3: A `tc` with `dir` = 1 (up) and no clear makes `cnt` equal to the old value plus one, modulo 2^m, so all ones wraps to 0.
- R4: A `tc` with `dir` = 0 (down) and no clear makes `cnt` equal to the old value minus one, modulo 2^m. This includes the first step after a reset or clear, where 0 becomes all ones.
- R5: The first `tc` after the direction changes yields the value the counter held before its last step, which is the correct one-step move in the new direction.
- R6: When the direction flips on every `tc` for any number of strobes, `cnt` alternates between two neighbouring values and never drifts.
- R7: `clr` takes priority over `tc`. A cycle with both high leaves `cnt` at 0, and the next step counts from 0.
- R8: Changes of `dir` in cycles where `tc` is low have no effect. Only the value of `dir` in a `tc` cycle decides that step and whether it counts as a reversal.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| clr | input | 1 | Synchronous clear to zero, overrides `tc` |
| tc | input | 1 | One-cycle step strobe from the enable counter |
| dir | input | 1 | Step direction: 1 = up, 0 = down; sampled only with `tc` |
| cnt | output | WIDTH | Present slice value |

## Verification
A wrong flip-vector register or a wrong controller state stays hidden while the direction is steady. It shows up on the first `tc` after a reversal, and that step lands on a value other than the neighbour of the old one. For this reason the reference is a plain modular up/down model, and every sampled value is compared one edge after its strobe. The stimulus is built to make reversals frequent: single reversals after long runs, flips on every strobe, reversals straight after a clear, and `dir` toggling between strobes. A corrupted flip vector after a clear shows up on the first down step, and a chain fault shows up at the all-ones to zero wrap.

// File: rtl/updn_slice_pkg.sv
package updn_slice_pkg;

  typedef enum logic [1:0] {
    CTL_INIT = 2'd0,
    CTL_UP   = 2'd1,
    CTL_DOWN = 2'd2
  } ctl_state_e;

endpackage

// File: rtl/updn_has_chain.sv
// Ripple chain of half adder/subtractor cells. The sum is a ^ cin in either
// direction. The carry out depends on the direction that produced the present
// value. On a reversal each bit instead takes a ^ (stored flip bit).
module updn_has_chain #(
  parameter int WIDTH = 8
) (
  input  logic [WIDTH-1:0] cur,
  input  logic [WIDTH-1:0] flips_held,
  input  logic             prev_up,
  input  logic             reverse,
  output logic [WIDTH-1:0] nxt,
  output logic [WIDTH-1:0] ripple
);

  logic [WIDTH-1:0] cin_v;

  assign cin_v[0] = 1'b1;

  for (genvar i = 0; i < WIDTH; i++) begin : g_cell
    if (i < WIDTH - 1) begin : g_carry
      assign cin_v[i+1] = prev_up ? (cur[i] & cin_v[i]) : (~cur[i] & cin_v[i]);
    end
    assign nxt[i] = reverse ? (cur[i] ^ flips_held[i]) : (cur[i] ^ cin_v[i]);
  end

  assign ripple = cin_v;

endmodule

// File: rtl/updn_dir_ctrl.sv
// Direction controller. It advances only on tc. Its outputs combine the
// held state with dir.
module updn_dir_ctrl
  import updn_slice_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic tc,
  input  logic dir,
  output logic prev_up,
  output logic reverse
);

  ctl_state_e st_q;
  ctl_state_e st_d;

  always_comb begin
    st_d    = st_q;
    prev_up = dir;
    reverse = 1'b0;
    unique case (st_q)
      CTL_INIT: begin
        prev_up = dir;
        reverse = ~dir;
      end
      CTL_UP: begin
        prev_up = 1'b1;
        reverse = ~dir;
      end
      CTL_DOWN: begin
        prev_up = 1'b0;
        reverse = dir;
      end
      default: begin
        prev_up = dir;
        reverse = 1'b0;
      end
    endcase
    if (tc) st_d = dir ? CTL_UP : CTL_DOWN;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    st_q <= CTL_INIT;
    else if (clr)  st_q <= CTL_INIT;
    else           st_q <= st_d;
  end

  // R5: any step leaves the initial state
  p_leave_init_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (tc && !clr) |=> (st_q != CTL_INIT));

  // R3: steady up never flags a reversal
  p_steady_up_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == CTL_UP && dir) |-> !reverse);

  // R4: steady down never flags a reversal
  p_steady_dn_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == CTL_DOWN && !dir) |-> !reverse);

  // R8: the state is frozen between strobes
  p_idle_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!tc && !clr) |=> $stable(st_q));

endmodule

// File: rtl/updn_slice.sv
module updn_slice #(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             tc,
  input  logic             dir,
  output logic [WIDTH-1:0] cnt
);

  localparam logic [WIDTH-1:0] ALL_ONES = {WIDTH{1'b1}};
  localparam logic [WIDTH-1:0] UNIT     = WIDTH'(1);

  logic [WIDTH-1:0] cnt_q;
  logic [WIDTH-1:0] flips_q;
  logic [WIDTH-1:0] nxt;
  logic [WIDTH-1:0] ripple;
  logic             prev_up;
  logic             reverse;

  updn_dir_ctrl u_ctrl (
    .clk     (clk),
    .rst_n   (rst_n),
    .clr     (clr),
    .tc      (tc),
    .dir     (dir),
    .prev_up (prev_up),
    .reverse (reverse)
  );

  updn_has_chain #(.WIDTH(WIDTH)) u_chain (
    .cur        (cnt_q),
    .flips_held (flips_q),
    .prev_up    (prev_up),
    .reverse    (reverse),
    .nxt        (nxt),
    .ripple     (ripple)
  );

  // Count register: loads only on a step strobe
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    cnt_q <= '0;
    else if (clr)  cnt_q <= '0;
    else if (tc)   cnt_q <= nxt;
  end

  // Flip vector: all ones after clear, captured on normal steps, kept on reversals
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 flips_q <= ALL_ONES;
    else if (clr)               flips_q <= ALL_ONES;
    else if (tc && !reverse)    flips_q <= ripple;
  end

  assign cnt = cnt_q;

  // R1: clear drives the value to zero
  p_clear_zero_r1: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (cnt_q == '0));

  // R2: no strobe, no change
  p_idle_stable_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!tc && !clr) |=> $stable(cnt_q));

  // R3: up step adds one modulo 2^WIDTH
  p_step_up_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (tc && !clr && dir) |=> (cnt_q == $past(cnt_q) + UNIT));

  // R4: down step subtracts one modulo 2^WIDTH
  p_step_dn_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (tc && !clr && !dir) |=> (cnt_q == $past(cnt_q) - UNIT));

  // R5: a reversal keeps the stored flip vector for later reversals
  p_flip_keep_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (tc && !clr && reverse) |=> $stable(flips_q));

endmodule

// File: tb/updn_slice_tb.sv
module updn_slice_tb;

  localparam int W = 8;

  logic         clk = 1'b0;
  logic         rst_n;
  logic         clr;
  logic         tc;
  logic         dir;
  logic [W-1:0] cnt;

  always #10 clk = ~clk;

  updn_slice #(.WIDTH(W)) u_dut (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (clr),
    .tc    (tc),
    .dir   (dir),
    .cnt   (cnt)
  );

  logic [W-1:0] exp_q[$];
  string        tag_q[$];
  int           total = 0;
  int           bad   = 0;
  logic [W-1:0] model = '0;
  logic         last_dir = 1'b1;
  logic         stepped  = 1'b0;
  logic         done     = 1'b0;

  // Driver: applies one cycle of stimulus and pushes the expected next value
  task automatic step(input logic t, input logic d, input logic c, input string tg);
    string use_tag;
    @(negedge clk);
    tc  = t;
    dir = d;
    clr = c;
    if (c)                            use_tag = "R7";
    else if (!t)                      use_tag = "R2";
    else if (stepped && d != last_dir) use_tag = "R5";
    else                              use_tag = d ? "R3" : "R4";
    if (tg != "") use_tag = tg;
    if (c) begin
      model   = '0;
      stepped = 1'b0;
    end else if (t) begin
      model    = d ? model + W'(1) : model - W'(1);
      last_dir = d;
      stepped  = 1'b1;
    end
    exp_q.push_back(model);
    tag_q.push_back(use_tag);
  endtask

  // Monitor: compares after each edge, away from it
  always @(posedge clk) begin
    logic [W-1:0] e;
    string        tg;
    #2;
    if (rst_n && exp_q.size() > 0) begin
      e  = exp_q.pop_front();
      tg = tag_q.pop_front();
      total++;
      if (cnt !== e) begin
        bad++;
        $display("FAIL %s: cnt got %0h expected %0h", tg, cnt, e);
      end
    end
  end

  // Watchdog
  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    clr   = 1'b0;
    tc    = 1'b0;
    dir   = 1'b1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    total++;
    if (cnt !== '0) begin
      bad++;
      $display("FAIL R1: cnt after reset got %0h expected 0", cnt);
    end

    // R4: down from cleared zero, then more downs
    step(1'b1, 1'b0, 1'b0, "R4");
    for (int i = 0; i < 3; i++) step(1'b1, 1'b0, 1'b0, "");
    // R5: reverse after a run of downs
    step(1'b1, 1'b1, 1'b0, "R5");

    // R1: synchronous clear
    step(1'b0, 1'b1, 1'b1, "R1");

    // R3: long up run crossing the all-ones to zero wrap
    for (int i = 0; i < 260; i++) step(1'b1, 1'b1, 1'b0, "");

    // R6: flip direction on every strobe
    for (int i = 0; i < 10; i++) step(1'b1, (i % 2) == 0 ? 1'b0 : 1'b1, 1'b0, "R6");
    for (int i = 0; i < 5; i++) begin
      step(1'b1, 1'b0, 1'b0, "R6");
      step(1'b0, 1'b1, 1'b0, "R6");
      step(1'b1, 1'b1, 1'b0, "R6");
    end

    // R8: dir toggles with no strobe, then a strobe decides
    for (int i = 0; i < 6; i++) step(1'b0, (i % 2) == 0 ? 1'b0 : 1'b1, 1'b0, "R8");
    step(1'b1, 1'b1, 1'b0, "R8");
    for (int i = 0; i < 5; i++) step(1'b0, (i % 2) == 0 ? 1'b1 : 1'b0, 1'b0, "R8");
    step(1'b1, 1'b0, 1'b0, "R8");

    // R7: clear together with a strobe, then a down step from zero
    step(1'b1, 1'b1, 1'b1, "R7");
    step(1'b1, 1'b0, 1'b0, "R7");
    // reversal right after a clear-and-down
    step(1'b1, 1'b1, 1'b0, "R5");

    // Mixed random traffic
    for (int i = 0; i < 4000; i++) begin
      logic t, d, c;
      t = ($urandom % 3) == 0;
      d = (($urandom % 3) == 0) ? ~last_dir : last_dir;
      c = ($urandom % 300) == 0;
      step(t, d, c, "");
    end

    @(negedge clk);
    tc  = 1'b0;
    clr = 1'b0;
    repeat (3) @(negedge clk);
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule